// File: doc/BRIEF.md
# Register-Driven JTAG Scan Master

This block lets a processor operate an external JTAG test access port through a small byte-wide register window. It offers two ways of working. In direct mode, software sets the TCK, TMS and TDI pin levels itself and reads back the TDO level. In buffered mode, software fills a TMS byte buffer and a TDI byte buffer, programs a bit count and a clock divider, and writes a start bit. The shift engine then produces TCK, walks through the two buffers one bit per TCK period, stores TDO in a receive buffer and raises done, or done together with error.

Because TMS and TDI are given bit by bit in parallel, one buffered transfer can script any walk through the TAP state machine together with the data it shifts. The block does not track the TAP state and gives no meaning to the bits.

Register window (5-bit byte address): 0x00 control (bit 0 start, which always reads 0; bit 1 direct mode when 1), 0x01 status (bit 0 done, bit 1 error, read only), 0x02 direct pins (bit 0 TMS, bit 1 TDI), 0x03 direct TCK (bit 0), 0x04 TDO level (bit 0, read only, passed through a synchronizer), 0x05 divider, 0x06 bit count, 0x08+k TDI byte k, 0x10+k TMS byte k, 0x18+k receive byte k (read only). Addresses that are not mapped read as 0.

Top module: `jtag_scan_master`

## Requirements
- R1: After reset, every readable register returns 0 and jtag_tck, jtag_tms and jtag_tdi are low.
- R2: While control bit 1 is 1, jtag_tms follows bit 0 and jtag_tdi follows bit 1 of register 0x02, and jtag_tck follows bit 0 of register 0x03, from the cycle after the write. Bit 0 of register 0x04 returns the jtag_tdo level after SYNC_STAGES clock cycles.
- R3: Control bit 1 selects the pin source: 1 gives direct register control, 0 gives the shift engine. It reads back at bit 1 of address 0x00.
- R4: With divider value N, a buffered transfer runs TCK with a period of 2*(N+1) system clocks and a 50% duty cycle. When the shift engine drives the pins and no transfer is running, TCK is low.
- R5: A transfer of C bits sends bit i of the TMS and TDI buffers (byte i/8, bit i%8) in the i-th TCK period, starting at i=0. TMS and TDI change only at the falling TCK edge. The TDO level at the i-th rising edge is stored in bit i of the receive buffer. An accepted start clears the receive buffer, so receive bits at or above C read 0.
- R6: Writing 1 to control bit 0 with bit 1 at 0 while idle starts a transfer and clears done and error. When the last bit completes, done is set.
- R7: A start with a count of 0, or a count above NUM_BYTES*8, sets done and error together, makes no TCK pulse and leaves the receive buffer unchanged.
- R8: While a transfer runs, writes to the TDI and TMS buffers, the count register, the mode bit and the start bit have no effect.
- R9: A start written together with control bit 1 = 1 does not start a transfer.
- R10: Writes to the status register have no effect on done and error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| jtag_tck | output | 1 | Test clock to the TAP |
| jtag_tms | output | 1 | Test mode select to the TAP |
| jtag_tdi | output | 1 | Test data to the TAP |
| jtag_tdo | input | 1 | Test data from the TAP |

## Verification
The bench builds the block with five bytes per buffer, a 6-bit count, a 4-bit divider and a two-stage TDO synchronizer. With the 4-bit divider, every divider value from 0 to 15 can be tested, so TCK periods from 2 to 32 clocks are measured edge to edge. With five bytes, the full 40-bit transfer and the first illegal count of 41 are both in range. The TAP is modelled as TDO = TDI xor TMS xor a per-transfer inversion, so each receive bit shows whether sampling happened at the rising edge of the correct bit.

// File: rtl/jtag_master_pkg.sv
package jtag_master_pkg;

   localparam int ADDR_W = 5;

   localparam logic [ADDR_W-1:0] ADR_CTRL   = 5'h00;
   localparam logic [ADDR_W-1:0] ADR_STATUS = 5'h01;
   localparam logic [ADDR_W-1:0] ADR_PINS   = 5'h02;
   localparam logic [ADDR_W-1:0] ADR_TCKB   = 5'h03;
   localparam logic [ADDR_W-1:0] ADR_TDOB   = 5'h04;
   localparam logic [ADDR_W-1:0] ADR_DIV    = 5'h05;
   localparam logic [ADDR_W-1:0] ADR_COUNT  = 5'h06;

   // address bits [4:3] select a region, bits [2:0] select the entry
   localparam logic [1:0] RGN_MISC = 2'b00;
   localparam logic [1:0] RGN_TDI  = 2'b01;
   localparam logic [1:0] RGN_TMS  = 2'b10;
   localparam logic [1:0] RGN_RX   = 2'b11;

   typedef struct packed {
      logic error;
      logic done;
   } jm_status_t;

endpackage

// File: rtl/jtag_tck_div.sv
module jtag_tck_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine #(
   parameter int NUM_BYTES = 5,
   parameter int CNT_W     = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    launch,
   input  logic [CNT_W-1:0]        count,
   input  logic [NUM_BYTES*8-1:0]  tdi_vec,
   input  logic [NUM_BYTES*8-1:0]  tms_vec,
   input  logic                    tdo_in,
   input  logic                    tick,
   output logic                    busy,
   output jtag_master_pkg::jm_status_t status,
   output logic                    eng_tck,
   output logic                    eng_tms,
   output logic                    eng_tdi,
   output logic [NUM_BYTES*8-1:0]  rx_vec
);

   localparam int TOT_BITS = NUM_BYTES * 8;
   localparam int IDX_W    = $clog2(TOT_BITS);

   logic [IDX_W-1:0]    idx_q;
   logic [TOT_BITS-1:0] rx_q;
   logic                busy_q, tck_q, done_q, err_q;
   logic                bad_count, last_bit;

   assign bad_count = (count == '0) || (count > CNT_W'(TOT_BITS));
   assign last_bit  = ((CNT_W'(idx_q) + CNT_W'(1)) == count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tck_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         idx_q  <= '0;
         rx_q   <= '0;
      end else if (launch) begin
         if (bad_count) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
         end else begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            tck_q  <= 1'b0;
            idx_q  <= '0;
            rx_q   <= '0;
         end
      end else if (busy_q && tick) begin
         if (!tck_q) begin
            tck_q       <= 1'b1;
            rx_q[idx_q] <= tdo_in;
         end else begin
            tck_q <= 1'b0;
            if (last_bit) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign busy         = busy_q;
   assign status.done  = done_q;
   assign status.error = err_q;
   assign eng_tck      = tck_q;
   assign eng_tms      = busy_q & tms_vec[idx_q];
   assign eng_tdi      = busy_q & tdi_vec[idx_q];
   assign rx_vec       = rx_q;

endmodule

// File: rtl/jtag_reg_file.sv
module jtag_reg_file
   import jtag_master_pkg::*;
#(
   parameter int NUM_BYTES   = 5,
   parameter int CNT_W       = 6,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [7:0]             wdata,
   output logic [7:0]             rdata,
   input  logic                   busy,
   input  jm_status_t             status,
   input  logic [NUM_BYTES*8-1:0] rx_vec,
   input  logic                   tdo_pin,
   output logic                   mode_direct,
   output logic                   dir_tms,
   output logic                   dir_tdi,
   output logic                   dir_tck,
   output logic [DIV_W-1:0]       div_val,
   output logic [CNT_W-1:0]       count,
   output logic [NUM_BYTES*8-1:0] tdi_vec,
   output logic [NUM_BYTES*8-1:0] tms_vec,
   output logic                   start_pulse
);

   logic             mode_q, tckb_q, tdo_sync;
   logic [1:0]       pins_q;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] cnt_q;
   logic [7:0]       tdi_b [NUM_BYTES];
   logic [7:0]       tms_b [NUM_BYTES];
   logic             wr_ctrl, locked_ok;

   assign wr_ctrl     = wr_en && (addr == ADR_CTRL);
   assign locked_ok   = wr_en && !busy;
   assign start_pulse = wr_ctrl && !busy && wdata[0] && !wdata[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         pins_q <= '0;
         tckb_q <= 1'b0;
         div_q  <= '0;
         cnt_q  <= '0;
      end else if (wr_en) begin
         if (wr_ctrl && !busy)         mode_q <= wdata[1];
         if (addr == ADR_PINS)         pins_q <= wdata[1:0];
         if (addr == ADR_TCKB)         tckb_q <= wdata[0];
         if (addr == ADR_DIV)          div_q  <= wdata[DIV_W-1:0];
         if (addr == ADR_COUNT && !busy) cnt_q <= wdata[CNT_W-1:0];
      end
   end

   // per-byte shift buffers
   for (genvar k = 0; k < NUM_BYTES; k++) begin : g_buf
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tdi_b[k] <= '0;
            tms_b[k] <= '0;
         end else if (locked_ok && addr[2:0] == 3'(k)) begin
            if (addr[4:3] == RGN_TDI) tdi_b[k] <= wdata;
            if (addr[4:3] == RGN_TMS) tms_b[k] <= wdata;
         end
      end
      assign tdi_vec[k*8 +: 8] = tdi_b[k];
      assign tms_vec[k*8 +: 8] = tms_b[k];
   end

   // TDO level synchronizer for the direct readback
   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tdo_sync <= 1'b0;
         else        tdo_sync <= tdo_pin;
      end
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[SYNC_STAGES-2:0], tdo_pin};
      end
      assign tdo_sync = chain_q[SYNC_STAGES-1];
   end

   always_comb begin
      rdata = '0;
      unique case (addr[4:3])
         RGN_MISC: begin
            unique case (addr[2:0])
               3'd0:    rdata = {6'b0, mode_q, 1'b0};
               3'd1:    rdata = {6'b0, status.error, status.done};
               3'd2:    rdata = {6'b0, pins_q};
               3'd3:    rdata = {7'b0, tckb_q};
               3'd4:    rdata = {7'b0, tdo_sync};
               3'd5:    rdata = 8'(div_q);
               3'd6:    rdata = 8'(cnt_q);
               default: rdata = '0;
            endcase
         end
         RGN_TDI: for (int k = 0; k < NUM_BYTES; k++) if (addr[2:0] == 3'(k)) rdata = tdi_b[k];
         RGN_TMS: for (int k = 0; k < NUM_BYTES; k++) if (addr[2:0] == 3'(k)) rdata = tms_b[k];
         RGN_RX:  for (int k = 0; k < NUM_BYTES; k++) if (addr[2:0] == 3'(k)) rdata = rx_vec[k*8 +: 8];
         default: rdata = '0;
      endcase
   end

   assign mode_direct = mode_q;
   assign dir_tms     = pins_q[0];
   assign dir_tdi     = pins_q[1];
   assign dir_tck     = tckb_q;
   assign div_val     = div_q;
   assign count       = cnt_q;

endmodule

// File: rtl/jtag_scan_master.sv
module jtag_scan_master
   import jtag_master_pkg::*;
#(
   parameter int NUM_BYTES   = 5,
   parameter int CNT_W       = 6,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              jtag_tck,
   output logic              jtag_tms,
   output logic              jtag_tdi,
   input  logic              jtag_tdo
);

   localparam int TOT_BITS = NUM_BYTES * 8;

   if (NUM_BYTES < 1 || NUM_BYTES > 8) begin : g_bad_bytes
      $error("NUM_BYTES must lie in 1..8");
   end
   if (CNT_W > 8 || (1 << CNT_W) <= TOT_BITS) begin : g_bad_cnt
      $error("CNT_W must hold NUM_BYTES*8 and fit a byte");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must lie in 1..8");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 1..4");
   end

   logic                  mode_direct, dir_tms, dir_tdi, dir_tck;
   logic                  start_pulse, eng_busy, tick;
   logic                  eng_tck, eng_tms, eng_tdi;
   logic [DIV_W-1:0]      div_val;
   logic [CNT_W-1:0]      count;
   logic [TOT_BITS-1:0]   tdi_vec, tms_vec, rx_vec;
   jm_status_t            eng_status;

   jtag_reg_file #(
      .NUM_BYTES(NUM_BYTES), .CNT_W(CNT_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .busy(eng_busy), .status(eng_status), .rx_vec(rx_vec),
      .tdo_pin(jtag_tdo), .mode_direct(mode_direct), .dir_tms(dir_tms),
      .dir_tdi(dir_tdi), .dir_tck(dir_tck), .div_val(div_val), .count(count),
      .tdi_vec(tdi_vec), .tms_vec(tms_vec), .start_pulse(start_pulse)
   );

   jtag_tck_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(eng_busy), .div_val(div_val), .tick(tick)
   );

   jtag_shift_engine #(.NUM_BYTES(NUM_BYTES), .CNT_W(CNT_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .launch(start_pulse), .count(count),
      .tdi_vec(tdi_vec), .tms_vec(tms_vec), .tdo_in(jtag_tdo), .tick(tick),
      .busy(eng_busy), .status(eng_status), .eng_tck(eng_tck),
      .eng_tms(eng_tms), .eng_tdi(eng_tdi), .rx_vec(rx_vec)
   );

   assign jtag_tck = mode_direct ? dir_tck : eng_tck;
   assign jtag_tms = mode_direct ? dir_tms : eng_tms;
   assign jtag_tdi = mode_direct ? dir_tdi : eng_tdi;

endmodule

// File: rtl/jtag_scan_master_chk.sv
module jtag_scan_master_chk #(
   parameter int CNT_W    = 6,
   parameter int TOT_BITS = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_direct,
   input logic             busy,
   input logic             done,
   input logic             error,
   input logic [CNT_W-1:0] count,
   input logic             jtag_tck,
   input logic             jtag_tms,
   input logic             jtag_tdi
);

   AST_TCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_direct && !busy) |-> !jtag_tck);  // R4

   AST_BITS_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_direct && busy && jtag_tck) |-> ($stable(jtag_tms) && $stable(jtag_tdi)));  // R5

   AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!done && !error));  // R6

   AST_DONE_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> busy);  // R6

   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);  // R7

   AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (count != '0 && count <= CNT_W'(TOT_BITS)));  // R7

   AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(count));  // R8

   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mode_direct));  // R8

endmodule

bind jtag_scan_master jtag_scan_master_chk #(
   .CNT_W(CNT_W), .TOT_BITS(NUM_BYTES * 8)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_direct(mode_direct), .busy(eng_busy),
   .done(eng_status.done), .error(eng_status.error), .count(count),
   .jtag_tck(jtag_tck), .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi)
);

// File: tb/tb_jtag_scan_master.sv
`timescale 1ns/1ps
module tb_jtag_scan_master;

   localparam int  NB   = 5;
   localparam int  TOT  = NB * 8;
   localparam real TCLK = 5.0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       jtag_tck, jtag_tms, jtag_tdi, jtag_tdo;
   logic       tdo_inv = 1'b0;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  mon_en = 1'b0;
   int  rise_n = 0;
   int  cur_div = 0;
   real last_rise = 0.0;
   bit [63:0] rec_tms, rec_tdi;

   always #(TCLK/2.0) clk = ~clk;

   // TAP model: TDO mixes the bits it is sent with a per-transfer inversion
   assign jtag_tdo = jtag_tdi ^ jtag_tms ^ tdo_inv;

   jtag_scan_master #(.NUM_BYTES(NB), .CNT_W(6), .DIV_W(4), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .jtag_tck(jtag_tck),
      .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi), .jtag_tdo(jtag_tdo)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // TCK edge monitor: bit order and period (R4, R5)
   always @(posedge jtag_tck) begin
      if (mon_en) begin
         if (rise_n < 64) begin
            rec_tms[rise_n] = jtag_tms;
            rec_tdi[rise_n] = jtag_tdi;
         end
         if (rise_n > 0) begin
            real d;
            real e;
            d = $realtime - last_rise;
            e = 2.0 * (cur_div + 1) * TCLK;
            chk((d - e) < 0.1 && (e - d) < 0.1, "R4 tck period", 64'(int'(d)), 64'(int'(e)));
         end
         last_rise = $realtime;
         rise_n++;
      end
   end

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   function automatic bit [39:0] exp_rx(input bit [39:0] tdi, input bit [39:0] tms, input bit inv, input int cnt);
      bit [39:0] r = '0;
      for (int i = 0; i < cnt; i++) r[i] = tdi[i] ^ tms[i] ^ inv;
      return r;
   endfunction

   task automatic load(input int cnt, input int dv, input bit [39:0] tdi, input bit [39:0] tms);
      wr(5'h05, 8'(dv));
      wr(5'h06, 8'(cnt));
      for (int k = 0; k < NB; k++) begin
         wr(5'(8 + k), tdi[k*8 +: 8]);
         wr(5'(16 + k), tms[k*8 +: 8]);
      end
      cur_div = dv;
   endtask

   task automatic wait_done(output logic [7:0] st);
      st = '0;
      for (int i = 0; i < 4000 && !st[0]; i++) rd(5'h01, st);
   endtask

   task automatic read_rx(output bit [39:0] v);
      logic [7:0] b;
      for (int k = 0; k < NB; k++) begin
         rd(5'(24 + k), b);
         v[k*8 +: 8] = b;
      end
   endtask

   task automatic xfer(input int cnt, input int dv, input bit [39:0] tdi, input bit [39:0] tms, input bit inv);
      logic [7:0] st;
      bit [39:0]  rx;
      bit [63:0]  m;
      load(cnt, dv, tdi, tms);
      tdo_inv = inv;
      rise_n = 0; rec_tms = '0; rec_tdi = '0;
      mon_en = 1'b1;
      wr(5'h00, 8'h01);
      rd(5'h01, st);
      chk(st[1:0] == 2'b00, "R6 start clears status", 64'(st), 64'h0);
      wait_done(st);
      mon_en = 1'b0;
      chk(st[1:0] == 2'b01, "R6 done without error", 64'(st), 64'h1);
      chk(rise_n == cnt, "R5 rising edge count", 64'(rise_n), 64'(cnt));
      m = (64'h1 << cnt) - 1;
      chk((rec_tms & m) == (64'(tms) & m), "R5 tms bit order", rec_tms & m, 64'(tms) & m);
      chk((rec_tdi & m) == (64'(tdi) & m), "R5 tdi bit order", rec_tdi & m, 64'(tdi) & m);
      read_rx(rx);
      chk(rx == exp_rx(tdi, tms, inv, cnt), "R5 receive buffer", 64'(rx), 64'(exp_rx(tdi, tms, inv, cnt)));
      chk(jtag_tck == 1'b0, "R4 tck idle low", 64'(jtag_tck), 64'h0);
   endtask

   task automatic bad_start(input int cnt, input bit [39:0] rx_before);
      logic [7:0] st;
      bit [39:0]  rx;
      wr(5'h06, 8'(cnt));
      rise_n = 0; mon_en = 1'b1;
      wr(5'h00, 8'h01);
      repeat (20) @(negedge clk);
      mon_en = 1'b0;
      rd(5'h01, st);
      chk(st[1:0] == 2'b11, "R7 done and error", 64'(st), 64'h3);
      chk(rise_n == 0, "R7 no tck pulse", 64'(rise_n), 64'h0);
      read_rx(rx);
      chk(rx == rx_before, "R7 receive buffer kept", 64'(rx), 64'(rx_before));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d, st;
      bit [39:0]  a, b, rx_keep;
      int unsigned seed;
      seed = $urandom(32'h1A7C_0042);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      for (int ad = 0; ad < 32; ad++) begin
         rd(5'(ad), d);
         if (ad != 4) chk(d == 8'h00, "R1 register reset", 64'(d), 64'h0);
      end
      chk({jtag_tck, jtag_tms, jtag_tdi} == 3'b000, "R1 pins reset", 64'({jtag_tck, jtag_tms, jtag_tdi}), 64'h0);

      // R2, R3: direct pin control
      wr(5'h00, 8'h02);
      rd(5'h00, d);
      chk(d == 8'h02, "R3 mode readback", 64'(d), 64'h2);
      wr(5'h02, 8'h03);
      wr(5'h03, 8'h01);
      chk({jtag_tck, jtag_tdi, jtag_tms} == 3'b111, "R2 direct pins high", 64'({jtag_tck, jtag_tdi, jtag_tms}), 64'h7);
      tdo_inv = 1'b1;
      repeat (3) @(negedge clk);
      rd(5'h04, d);
      chk(d == 8'h01, "R2 tdo readback", 64'(d), 64'h1);
      wr(5'h02, 8'h02);
      wr(5'h03, 8'h00);
      chk({jtag_tck, jtag_tdi, jtag_tms} == 3'b010, "R2 direct pins mixed", 64'({jtag_tck, jtag_tdi, jtag_tms}), 64'h2);
      tdo_inv = 1'b0;
      repeat (3) @(negedge clk);
      rd(5'h04, d);
      chk(d == 8'h01, "R2 tdo follows tdi", 64'(d), 64'h1);

      // R9: start while selecting direct mode does nothing
      wr(5'h06, 8'd8);
      rise_n = 0; mon_en = 1'b1;
      wr(5'h03, 8'h00);
      wr(5'h00, 8'h03);
      repeat (40) @(negedge clk);
      mon_en = 1'b0;
      rd(5'h01, st);
      chk(st == 8'h00 && rise_n == 0, "R9 no launch in direct mode", 64'({st, 8'(rise_n)}), 64'h0);

      // R3: back to engine, pins low at idle
      wr(5'h00, 8'h00);
      chk({jtag_tck, jtag_tms, jtag_tdi} == 3'b000, "R3 engine idle pins", 64'({jtag_tck, jtag_tms, jtag_tdi}), 64'h0);

      // directed corners
      xfer(1,  0, 40'h00_0000_0001, 40'h00_0000_0000, 1'b0);
      xfer(40, 0, 40'hA5_3C_F0_0F_96, 40'h5A_C3_0F_F0_69, 1'b1);
      xfer(40, 15, 40'hFF_00_FF_00_81, 40'h12_34_56_78_9A, 1'b0);
      xfer(9,  2, 40'hFF_FF_FF_FF_FF, 40'h00_00_00_00_00, 1'b1);

      // constrained random transfers
      for (int t = 0; t < 10; t++) begin
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         xfer(1 + ($urandom % 40), $urandom % 16, a, b, 1'($urandom));
      end

      // R7: illegal counts
      read_rx(rx_keep);
      bad_start(0, rx_keep);
      bad_start(41, rx_keep);
      bad_start(63, rx_keep);

      // R10: status not writable
      wr(5'h01, 8'h00);
      rd(5'h01, st);
      chk(st[1:0] == 2'b11, "R10 status write ignored", 64'(st), 64'h3);

      // R8: writes during a running transfer
      a = 40'h11_22_33_44_55;
      b = 40'h0F_0E_0D_0C_0B;
      load(16, 3, a, b);
      tdo_inv = 1'b0;
      rise_n = 0; mon_en = 1'b1;
      wr(5'h00, 8'h01);
      rd(5'h01, st);
      chk(st[1:0] == 2'b00, "R6 start clears error", 64'(st), 64'h0);
      wr(5'h08, 8'hEE);
      wr(5'h10, 8'hDD);
      wr(5'h06, 8'd5);
      wr(5'h00, 8'h02);
      wr(5'h00, 8'h01);
      wait_done(st);
      mon_en = 1'b0;
      chk(rise_n == 16, "R8 count and start locked", 64'(rise_n), 64'd16);
      rd(5'h08, d);
      chk(d == 8'h55, "R8 tdi byte locked", 64'(d), 64'h55);
      rd(5'h10, d);
      chk(d == 8'h0B, "R8 tms byte locked", 64'(d), 64'h0B);
      rd(5'h06, d);
      chk(d == 8'd16, "R8 count register locked", 64'(d), 64'd16);
      rd(5'h00, d);
      chk(d == 8'h00, "R8 mode bit locked", 64'(d), 64'h0);
      read_rx(rx_keep);
      chk(rx_keep == exp_rx(a, b, 1'b0, 16), "R8 data shifted unchanged", 64'(rx_keep), 64'(exp_rx(a, b, 1'b0, 16)));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule